// File: doc/BRIEF.md
# Bidirectional Strobed Handshake Port

This block is a programmable parallel I/O controller with three 8-bit ports and one control register. A CPU reaches all four through a small bus: a 2-bit address, a read strobe, a write strobe, write data, and read data that follows the address combinationally. The CPU must not assert read and write in the same cycle. Port A is the data port, port B is a plain latched port, and port C is split into two 4-bit halves. The upper half of port C belongs to port A's group. The lower half belongs to port B's group. Each pin group has its own output-enable signal, and the enables stand in for tri-state buffers.

In simple mode every port is transparent. A written value appears on the pins at the next clock. A read in the input direction samples the live pins.

When port A's group is set to bidirectional mode, port A carries traffic in both directions on one set of pins, and control-port bits 3 to 7 become handshake lines:

- bit 7: output-buffer-full flag, active low, output.
- bit 6: peripheral acknowledge, active low, input.
- bit 5: input-buffer-full flag, output.
- bit 4: peripheral strobe, active low, input.
- bit 3: interrupt request, output.

Outbound data sits in a latch and reaches the pins only while the peripheral holds acknowledge low. Inbound data is captured when the strobe falls. Strobe and acknowledge pass through a two-flop synchroniser before their falling edges are detected. Port B and control bits 0 to 2 remain general I/O.

Top module: `duplex_port_ctrl`

## Requirements
- R1: After reset, the control register reads 0x9B. That value means every port is an input and both groups are in simple mode. pa_oe, pb_oe and all pc_oe bits are 0.
- R2: Bus addresses are: 0 = port A, 1 = port B, 2 = port C, 3 = control. A control write with bit 7 = 1 stores the mode fields: bits 6:5 = group A mode (1x bidirectional, otherwise simple), bit 4 = port A input, bit 3 = upper port C input, bit 2 = group B mode, bit 1 = port B input, bit 0 = lower port C input. A read of address 3 returns bit 7 as 1 and the stored fields below it. Such a write also clears the A, B and C output latches and all handshake state. A control write with bit 7 = 0 has no effect.
- R3: In simple mode, each port or half-port set to output drives its latch on its pins with the enable at 1. A read returns the latch for outputs and the live pins for inputs, bit by bit per half of port C.
- R4: In bidirectional mode, pc_oe[7:3] is 1,0,1,0,1 and pc_oe[2:0] follows bit 0 of the control word. CPU writes to port C do not change pc_out[7:3]. Write-data bit 6 sets the output interrupt enable and bit 4 sets the input interrupt enable. Both enables read back at the same bit positions of a port C read.
- R5: In bidirectional mode, pa_out holds the last value written to port A. pa_oe is 1 exactly while pc_in[6] (acknowledge, active low) is 0, with no clock delay.
- R6: pc_out[7] goes low at the clock after a CPU write to port A in bidirectional mode. It returns high within four clocks after pc_in[6] falls.
- R7: A fall on pc_in[4] (strobe, active low) captures pa_in into the input latch and sets pc_out[5] within four clocks. A read of port A returns the captured value, not the live pins, and clears pc_out[5].
- R8: pc_out[3] is 1 when either of two conditions holds: the output enable is set and acknowledge has completed since the last port A write, or the input enable is set and the input buffer is full. A port A write clears the output condition and a port A read clears the input condition. With both enables clear, pc_out[3] stays 0.
- R9: Port B stays a plain latched port, and its direction comes from control bit 1, while group A is in bidirectional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output value |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin input (bits 6 and 4 are handshake inputs in bidirectional mode) |
| pc_out | output | 8 | Port C pin output value |
| pc_oe | output | 8 | Port C per-bit drive enable |

## Verification
A wrong buffer-full flag appears on pc_out[7] or pc_out[5] within one clock of the bus access or synchronised edge that should have moved it. It also changes pc_out[3] in the same cycle. A wrong mode field shows at once in the enable pattern on pa_oe, pb_oe and pc_oe. A stale input latch, or a read path that returns the live pins, is exposed by the first port A read after the bench changes pa_in behind a completed strobe. A control write that fails to clear the output latches is visible on the output pins at the next clock.

// File: rtl/duplex_port_pkg.sv
package duplex_port_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] ADDR_PA   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PB   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PC   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

    // handshake positions on port C in bidirectional mode
    localparam int PC_OBF  = 7;
    localparam int PC_ACK  = 6;
    localparam int PC_IBF  = 5;
    localparam int PC_STB  = 4;
    localparam int PC_INTR = 3;
    localparam int LOW_KEEP = 3;   // bits that stay general I/O

    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h9B;

    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } mode_t;

    function automatic mode_t decode_ctrl(input logic [DATA_W-1:0] w);
        mode_t m;
        m.a_mode = w[6:5];
        m.a_in   = w[4];
        m.cu_in  = w[3];
        m.b_mode = w[2];
        m.b_in   = w[1];
        m.cl_in  = w[0];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] encode_ctrl(input mode_t m);
        return {1'b1, m.a_mode, m.a_in, m.cu_in, m.b_mode, m.b_in, m.cl_in};
    endfunction

    function automatic logic is_bidir(input mode_t m);
        return m.a_mode[1];
    endfunction

    // per-bit select: pins where sel is 1, latch elsewhere
    function automatic logic [DATA_W-1:0] pick_bits(input logic [DATA_W-1:0] sel,
                                                    input logic [DATA_W-1:0] pins,
                                                    input logic [DATA_W-1:0] lat);
        return (sel & pins) | (~sel & lat);
    endfunction

endpackage

// File: rtl/dpc_sync_fall.sv
module dpc_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign fall_o  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/dpc_ctrl_reg.sv
module dpc_ctrl_reg
    import duplex_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output mode_t             mode_o,
    output logic              mode_load_o
);
    mode_t mode_q;

    assign mode_load_o = wr_en_i & wdata_i[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst)              mode_q <= decode_ctrl(CTRL_RESET);
        else if (mode_load_o) mode_q <= decode_ctrl(wdata_i);
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/dpc_bidir_hs.sv
module dpc_bidir_hs
    import duplex_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_load_i,
    input  logic              cpu_wr_a_i,
    input  logic              cpu_rd_a_i,
    input  logic              cpu_wr_c_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ack_fall_i,
    input  logic              stb_fall_i,
    input  logic [DATA_W-1:0] pa_pins_i,
    output logic              obf_o,
    output logic              ibf_o,
    output logic              inte_out_o,
    output logic              inte_in_o,
    output logic              intr_o,
    output logic [DATA_W-1:0] in_latch_o
);
    logic obf_q, ibf_q, ie_out_q, ie_in_q, done_q;
    logic [DATA_W-1:0] in_q;

    always_ff @(posedge clk) begin
        if (rst || mode_load_i) begin
            obf_q    <= 1'b0;
            ibf_q    <= 1'b0;
            ie_out_q <= 1'b0;
            ie_in_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (cpu_wr_c_i) begin
                ie_out_q <= wdata_i[PC_ACK];
                ie_in_q  <= wdata_i[PC_STB];
            end
            if (cpu_wr_a_i) begin
                obf_q  <= 1'b1;
                done_q <= 1'b0;
            end else if (ack_fall_i) begin
                obf_q  <= 1'b0;
                done_q <= 1'b1;
            end
            if (stb_fall_i)      ibf_q <= 1'b1;
            else if (cpu_rd_a_i) ibf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             in_q <= '0;
        else if (stb_fall_i) in_q <= pa_pins_i;
    end

    assign obf_o      = obf_q;
    assign ibf_o      = ibf_q;
    assign inte_out_o = ie_out_q;
    assign inte_in_o  = ie_in_q;
    assign in_latch_o = in_q;
    assign intr_o     = (ie_out_q & done_q) | (ie_in_q & ibf_q);

    AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_a_i && !mode_load_i) |=> obf_o) else $error("obf"); // R6
    AST_IBF_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (stb_fall_i && !mode_load_i) |=> (ibf_o && in_latch_o == $past(pa_pins_i))) else $error("ibf"); // R7
    AST_INTR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        intr_o |-> (inte_out_o || inte_in_o)) else $error("intr"); // R8
endmodule

// File: rtl/duplex_port_ctrl.sv
module duplex_port_ctrl
    import duplex_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);
    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << LOW_KEEP) - 1);

    mode_t mode;
    logic  mode_load, bidir;
    logic  wr_a, wr_b, wr_c, rd_a;
    logic  ack_fall, stb_fall, ack_lvl, stb_lvl;
    logic  obf, ibf, ie_out, ie_in, intr;
    logic [DATA_W-1:0] in_latch;
    logic [DATA_W-1:0] lat_a, lat_b, lat_c;
    logic [DATA_W-1:0] c_in_sel, c_wr_mask, c_read;

    dpc_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (bus_wr && bus_addr == ADDR_CTRL),
        .wdata_i     (bus_wdata),
        .mode_o      (mode),
        .mode_load_o (mode_load)
    );

    assign bidir = is_bidir(mode);
    assign wr_a  = bus_wr && bus_addr == ADDR_PA;
    assign wr_b  = bus_wr && bus_addr == ADDR_PB;
    assign wr_c  = bus_wr && bus_addr == ADDR_PC;
    assign rd_a  = bus_rd && bus_addr == ADDR_PA;

    dpc_sync_fall #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .pin_i(pc_in[PC_ACK]), .level_o(ack_lvl), .fall_o(ack_fall)
    );
    dpc_sync_fall #(.STAGES(SYNC_STAGES)) u_stb_sync (
        .clk(clk), .rst(rst), .pin_i(pc_in[PC_STB]), .level_o(stb_lvl), .fall_o(stb_fall)
    );

    dpc_bidir_hs u_hs (
        .clk         (clk),
        .rst         (rst),
        .mode_load_i (mode_load),
        .cpu_wr_a_i  (bidir & wr_a),
        .cpu_rd_a_i  (bidir & rd_a),
        .cpu_wr_c_i  (bidir & wr_c),
        .wdata_i     (bus_wdata),
        .ack_fall_i  (bidir & ack_fall),
        .stb_fall_i  (bidir & stb_fall),
        .pa_pins_i   (pa_in),
        .obf_o       (obf),
        .ibf_o       (ibf),
        .inte_out_o  (ie_out),
        .inte_in_o   (ie_in),
        .intr_o      (intr),
        .in_latch_o  (in_latch)
    );

    // which port C bits the CPU may write
    assign c_wr_mask = bidir ? LOW_MASK : '1;

    always_ff @(posedge clk) begin
        if (rst || mode_load) begin
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
        end else begin
            if (wr_a) lat_a <= bus_wdata;
            if (wr_b) lat_b <= bus_wdata;
            if (wr_c) lat_c <= (lat_c & ~c_wr_mask) | (bus_wdata & c_wr_mask);
        end
    end

    // input-direction selector for port C, per half
    assign c_in_sel = {{HALF{mode.cu_in}}, {HALF{mode.cl_in}}};

    always_comb begin
        pa_out = lat_a;
        pb_out = lat_b;
        pb_oe  = ~mode.b_in;
        if (bidir) begin
            pa_oe  = ~pc_in[PC_ACK];
            pc_oe  = {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, {LOW_KEEP{~mode.cl_in}}};
            pc_out = {~obf, 1'b0, ibf, 1'b0, intr, lat_c[LOW_KEEP-1:0]};
            c_read = {~obf, ie_out, ibf, ie_in, intr,
                      mode.cl_in ? pc_in[LOW_KEEP-1:0] : lat_c[LOW_KEEP-1:0]};
        end else begin
            pa_oe  = ~mode.a_in;
            pc_oe  = ~c_in_sel;
            pc_out = lat_c;
            c_read = pick_bits(c_in_sel, pc_in, lat_c);
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_PA:   bus_rdata = bidir ? in_latch : (mode.a_in ? pa_in : lat_a);
            ADDR_PB:   bus_rdata = mode.b_in ? pb_in : lat_b;
            ADDR_PC:   bus_rdata = c_read;
            default:   bus_rdata = encode_ctrl(mode);
        endcase
    end

    logic unused_lvl;
    assign unused_lvl = ack_lvl ^ stb_lvl ^ mode.b_mode ^ mode.a_mode[0];

    AST_MODE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_CTRL && bus_wdata[DATA_W-1])
        |=> (pa_out == '0 && pb_out == '0)) else $error("clear"); // R2
    AST_PA_OE_ACK: assert property (@(posedge clk) disable iff (rst)
        (bidir && pc_in[PC_ACK]) |-> !pa_oe) else $error("pa_oe"); // R5
    AST_PC_HS_DIR: assert property (@(posedge clk) disable iff (rst)
        bidir |-> (pc_oe[DATA_W-1:LOW_KEEP] == 5'b10101)) else $error("pc_oe"); // R4
endmodule

// File: tb/duplex_port_ctrl_tb.sv
module duplex_port_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pa_in = '0, pa_out, pb_in = '0, pb_out, pc_in = 8'hFF, pc_out, pc_oe;
    logic       pa_oe, pb_oe;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    duplex_port_ctrl u_dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(2'd3, rv);
        chk("R1 ctrl", rv, 8'h9B);
        chk("R1 oe", {pa_oe, pb_oe, pc_oe}, 10'h0);

        // R2/R3 sweep over all direction combinations in simple mode
        for (int d = 0; d < 16; d++) begin
            logic [7:0] w, v, exp_c, cs;
            w = 8'h80 | (8'(d >> 3 & 1) << 4) | (8'(d >> 2 & 1) << 3)
                      | (8'(d >> 1 & 1) << 1) | 8'(d & 1);
            wr(2'd3, w);
            rd(2'd3, rv);
            chk("R2 ctrl readback", rv, w);
            chk("R2 latches cleared", pa_out | pb_out | pc_out, 8'h00);
            chk("R3 oe", {6'b0, pa_oe, pb_oe}, {6'b0, ~w[4], ~w[1]});
            chk("R3 pc_oe", pc_oe, {{4{~w[3]}}, {4{~w[0]}}});
            v = 8'(d * 17) ^ 8'h5A;
            wr(2'd0, v); wr(2'd1, ~v); wr(2'd2, v ^ 8'hC3);
            chk("R3 pa_out", pa_out, v);
            chk("R3 pb_out", pb_out, ~v);
            chk("R3 pc_out", pc_out, v ^ 8'hC3);
            pa_in = v + 8'd7; pb_in = v ^ 8'h99; pc_in = ~v;
            rd(2'd0, rv);
            chk("R3 read A", rv, w[4] ? v + 8'd7 : v);
            rd(2'd1, rv);
            chk("R3 read B", rv, w[1] ? (v ^ 8'h99) : ~v);
            cs = {{4{w[3]}}, {4{w[0]}}};
            exp_c = (cs & ~v) | (~cs & (v ^ 8'hC3));
            rd(2'd2, rv);
            chk("R3 read C", rv, exp_c);
        end

        // R2 write with bit 7 clear is ignored
        wr(2'd3, 8'h80);
        wr(2'd0, 8'hA5);
        wr(2'd3, 8'h1F);
        rd(2'd3, rv);
        chk("R2 ignored ctrl", rv, 8'h80);
        chk("R2 ignored latch", pa_out, 8'hA5);

        // bidirectional group A, port B and lower C outputs
        pc_in = 8'hFF; pa_in = 8'h00;
        wr(2'd3, 8'hC0);
        chk("R4 pc_oe", pc_oe, 8'hAF);
        chk("R4 idle handshake", pc_out[7:3], 5'b10000);
        wr(2'd2, 8'hFF);
        chk("R4 write C keeps hs bits", pc_out, 8'h87);
        rd(2'd2, rv);
        chk("R4 enables read back", {6'b0, rv[6], rv[4]}, 8'h03);

        // R5/R6/R8 outbound transfers
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = 8'(k * 53 + 9);
            wr(2'd0, v);
            chk("R6 obf low", {7'b0, pc_out[7]}, 8'h00);
            chk("R8 intr cleared by write", {7'b0, pc_out[3]}, 8'h00);
            chk("R5 oe off with ack high", {7'b0, pa_oe}, 8'h00);
            @(negedge clk); pc_in[6] = 1'b0;
            #1;
            chk("R5 oe on with ack low", {7'b0, pa_oe}, 8'h01);
            chk("R5 data", pa_out, v);
            repeat (4) @(negedge clk);
            chk("R6 obf high after ack", {7'b0, pc_out[7]}, 8'h01);
            chk("R8 intr after ack", {7'b0, pc_out[3]}, 8'h01);
            pc_in[6] = 1'b1;
            #1;
            chk("R5 oe off after ack", {7'b0, pa_oe}, 8'h00);
        end

        // keep only the input enable, then R7/R8 inbound transfers
        wr(2'd2, 8'h10);
        chk("R8 intr off without out enable", {7'b0, pc_out[3]}, 8'h00);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = 8'(k * 71 + 3);
            @(negedge clk); pa_in = v; pc_in[4] = 1'b0;
            repeat (4) @(negedge clk);
            pc_in[4] = 1'b1; pa_in = ~v;
            chk("R7 ibf set", {7'b0, pc_out[5]}, 8'h01);
            chk("R8 intr on ibf", {7'b0, pc_out[3]}, 8'h01);
            rd(2'd0, rv);
            chk("R7 latched data", rv, v);
            chk("R7 ibf cleared", {7'b0, pc_out[5]}, 8'h00);
            chk("R8 intr cleared by read", {7'b0, pc_out[3]}, 8'h00);
        end

        // R8 no interrupt with both enables clear
        wr(2'd2, 8'h00);
        @(negedge clk); pc_in[4] = 1'b0;
        repeat (4) @(negedge clk);
        pc_in[4] = 1'b1;
        chk("R8 ibf without enable", {7'b0, pc_out[5]}, 8'h01);
        chk("R8 intr masked", {7'b0, pc_out[3]}, 8'h00);

        // R9 port B in bidirectional mode
        wr(2'd1, 8'h3C);
        chk("R9 pb_out", pb_out, 8'h3C);
        chk("R9 pb_oe", {7'b0, pb_oe}, 8'h01);
        wr(2'd3, 8'hC2);
        chk("R2 mode write clears ibf", {7'b0, pc_out[5]}, 8'h00);
        pb_in = 8'h6E;
        rd(2'd1, rv);
        chk("R9 read B input", rv, 8'h6E);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule